// File: doc/BRIEF.md
# Tri-Level Serial Control Frame Receiver

This block takes a one-wire control line that idles at a middle voltage and pulses to a high or a low level for each bit. Two comparator flags present the line to the block: one is set while the line is above the upper threshold and one while it is below the lower threshold. Both are sampled on the system clock, synchronised and filtered. A bit is recovered whenever the line returns to the middle level. The level that came just before that return gives the bit value.

Forty recovered bits make a frame. The frame carries a header that names the device, then a register address, then a sixteen-bit data word. Frames with the wrong header or an unknown register are discarded. A frame aimed at the low register stages seven fine-resolution bits without touching the output. A frame aimed at the high register commits a 23-bit two's-complement control word, built from the new high part and the staged low part, and raises a one-cycle update strobe. If the line stays at the middle level longer than a programmable limit, any partial frame is discarded, so the receiver can find the start of the next frame after a broken transfer.

Top module: `trilvl_rx`

## Requirements
- R1: After reset `ctrl_word` is zero, which means mid-range, and `ctrl_upd` is low.
- R2: `line_hi`=1 is the high level, `line_lo`=1 is the low level, and both clear is the middle level. A high level followed by a return to middle is bit 1, and a low level followed by a return to middle is bit 0. Bits arrive MSB first and 40 make a frame: header in bits 39:24, register address in bits 23:16, data in bits 15:0.
- R3: A frame is accepted only if its header equals 0xFA in bits 15:8, `dev_addr` in bits 7:4 and 0xA in bits 3:0. Any other header leaves the output and the staged bits unchanged.
- R4: An accepted frame to register 0x06 sets `ctrl_word` to {data[15:0], staged[6:0]} and pulses `ctrl_upd` high for exactly one cycle.
- R5: An accepted frame to register 0x07 stores data[6:0] as the staged bits. It gives no `ctrl_upd` pulse and does not change `ctrl_word`, and the next 0x06 commit uses the staged bits.
- R6: An accepted header with any register address other than 0x06 or 0x07 changes nothing.
- R7: A line level is accepted only after FILT_N consecutive equal samples. Shorter excursions produce no bit.
- R8: When the middle level lasts `idle_limit` cycles, any partially received frame is discarded and the next bit starts a new frame.
- R9: `ctrl_upd` and the new `ctrl_word` appear together FILT_N+4 clock cycles after the line returns to middle at the end of the last bit. At all other times `ctrl_word` holds its value.
- R10: Staged bits persist across commits. A later 0x06 frame with no 0x07 frame before it reuses the last staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_hi | input | 1 | Comparator flag: line above upper threshold |
| line_lo | input | 1 | Comparator flag: line below lower threshold |
| dev_addr | input | 4 | Device address expected in the header |
| idle_limit | input | IDLE_W | Middle-level cycles that abandon a partial frame |
| ctrl_word | output | 23 | Committed two's-complement control word |
| ctrl_upd | output | 1 | One-cycle strobe marking a new control word |

## Verification
The only timed result is the commit. Two synchroniser stages, FILT_N filter samples, the frame stage and the register stage place it exactly FILT_N+4 cycles after the line returns to middle at the end of bit 0. The driver notes the cycle in which it releases the line to middle for that last bit, and pushes the expected word together with that cycle plus FILT_N+4. The monitor pops the entry on every strobe and compares both the word and the cycle number. Frames that must have no effect push nothing. For those, the bench reads `ctrl_word` once the whole frame has passed, and any strobe with an empty queue is reported.

// File: rtl/trilvl_pkg.sv
package trilvl_pkg;
  localparam int HDR_W   = 16;
  localparam int ADR_W   = 8;
  localparam int DAT_W   = 16;
  localparam int LO_W    = 7;
  localparam int DEV_W   = 4;
  localparam int FRAME_W = HDR_W + ADR_W + DAT_W;
  localparam int CTRL_W  = DAT_W + LO_W;

  localparam logic [7:0]       SYNC_TOP   = 8'hFA;
  localparam logic [3:0]       SYNC_TAIL  = 4'hA;
  localparam logic [ADR_W-1:0] ADR_COARSE = 8'h06;
  localparam logic [ADR_W-1:0] ADR_FINE   = 8'h07;

  typedef enum logic [1:0] {LV_MID = 2'd0, LV_HIGH = 2'd1, LV_LOW = 2'd2} lvl_t;

  // Both flags set is not a legal level and counts as middle.
  function automatic lvl_t lvl_decode(input logic hi, input logic lo);
    if (hi && !lo) return LV_HIGH;
    if (lo && !hi) return LV_LOW;
    return LV_MID;
  endfunction

  function automatic logic [HDR_W-1:0] hdr_expected(input logic [DEV_W-1:0] dev);
    return {SYNC_TOP, dev, SYNC_TAIL};
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_join(input logic [DAT_W-1:0] coarse,
                                                  input logic [LO_W-1:0] fine);
    return {coarse, fine};
  endfunction
endpackage

// File: rtl/trilvl_level_filter.sv
module trilvl_level_filter
  import trilvl_pkg::*;
#(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  input  logic line_lo,
  output lvl_t level
);
  localparam int CNT_W = $clog2(FILT_N + 1);

  logic [1:0] hi_sync, lo_sync;
  lvl_t raw_q, cand_q, level_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sync <= '0;
      lo_sync <= '0;
    end else begin
      hi_sync <= {hi_sync[0], line_hi};
      lo_sync <= {lo_sync[0], line_lo};
    end
  end

  assign raw_q = lvl_decode(hi_sync[1], lo_sync[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= LV_MID;
      cnt_q   <= '0;
      level_q <= LV_MID;
    end else if (raw_q != cand_q) begin
      cand_q <= raw_q;
      cnt_q  <= CNT_W'(1);
    end else begin
      if (cnt_q != CNT_W'(FILT_N)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FILT_N - 1)) level_q <= cand_q;
    end
  end

  assign level = level_q;

  AST_LEVEL_FROM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(raw_q) == level_q && $past(raw_q, 2) == level_q)); // R7
endmodule

// File: rtl/trilvl_bit_decoder.sv
module trilvl_bit_decoder
  import trilvl_pkg::*;
#(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lvl_t              level,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              resync
);
  lvl_t prev_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LV_MID;
      idle_q <= '0;
    end else begin
      prev_q <= level;
      if (level != LV_MID)          idle_q <= '0;
      else if (idle_q != idle_limit) idle_q <= idle_q + 1'b1;
    end
  end

  assign bit_stb = (level == LV_MID) && (prev_q != LV_MID);
  assign bit_val = (prev_q == LV_HIGH);
  assign resync  = (level == LV_MID) && (idle_q == idle_limit);

  AST_ONE_BIT_PER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R2
endmodule

// File: rtl/trilvl_frame_asm.sv
module trilvl_frame_asm
  import trilvl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic               resync,
  output logic               frame_stb,
  output logic [FRAME_W-1:0] frame
);
  localparam int BC_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shift_q;
  logic [BC_W-1:0]    bcnt_q;
  logic               stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bcnt_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (bit_stb) begin
        shift_q <= {shift_q[FRAME_W-2:0], bit_val};
        if (bcnt_q == BC_W'(FRAME_W - 1)) begin
          bcnt_q <= '0;
          stb_q  <= 1'b1;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end else if (resync) begin
        bcnt_q <= '0;
      end
    end
  end

  assign frame_stb = stb_q;
  assign frame     = shift_q;

  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb); // R2
  AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !bit_stb) |=> (bcnt_q == '0)); // R8
endmodule

// File: rtl/trilvl_ctrl_regs.sv
module trilvl_ctrl_regs
  import trilvl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_stb,
  input  logic [FRAME_W-1:0] frame,
  input  logic [DEV_W-1:0]   dev_addr,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic               ctrl_upd
);
  logic [HDR_W-1:0] f_hdr;
  logic [ADR_W-1:0] f_adr;
  logic [DAT_W-1:0] f_dat;
  logic             hdr_ok;
  logic [LO_W-1:0]  stage_q;
  logic [CTRL_W-1:0] word_q;
  logic             upd_q;

  assign f_hdr  = frame[FRAME_W-1 -: HDR_W];
  assign f_adr  = frame[DAT_W +: ADR_W];
  assign f_dat  = frame[DAT_W-1:0];
  assign hdr_ok = (f_hdr == hdr_expected(dev_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      word_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (frame_stb && hdr_ok) begin
        if (f_adr == ADR_COARSE) begin
          word_q <= ctrl_join(f_dat, stage_q);
          upd_q  <= 1'b1;
        end else if (f_adr == ADR_FINE) begin
          stage_q <= f_dat[LO_W-1:0];
        end
      end
    end
  end

  assign ctrl_word = word_q;
  assign ctrl_upd  = upd_q;

  AST_BAD_HDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !hdr_ok) |=> (!ctrl_upd && $stable(stage_q))); // R3
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd |=> !ctrl_upd); // R4
  AST_FINE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && f_adr == ADR_FINE) |=> ($stable(ctrl_word) && !ctrl_upd)); // R5
  AST_OTHER_ADR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && f_adr != ADR_COARSE && f_adr != ADR_FINE) |=> ($stable(stage_q) && !ctrl_upd)); // R6
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_upd |-> $stable(ctrl_word)); // R9
endmodule

// File: rtl/trilvl_rx.sv
module trilvl_rx
  import trilvl_pkg::*;
#(
  parameter int FILT_N = 4,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_hi,
  input  logic              line_lo,
  input  logic [3:0]        dev_addr,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic [22:0]       ctrl_word,
  output logic              ctrl_upd
);
  lvl_t               level;
  logic               bit_stb, bit_val, resync;
  logic               frame_stb;
  logic [FRAME_W-1:0] frame;

  trilvl_level_filter #(.FILT_N(FILT_N)) i_filter (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo), .level(level)
  );

  trilvl_bit_decoder #(.IDLE_W(IDLE_W)) i_decoder (
    .clk(clk), .rst_n(rst_n), .level(level), .idle_limit(idle_limit),
    .bit_stb(bit_stb), .bit_val(bit_val), .resync(resync)
  );

  trilvl_frame_asm i_asm (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val), .resync(resync),
    .frame_stb(frame_stb), .frame(frame)
  );

  trilvl_ctrl_regs i_regs (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .frame(frame),
    .dev_addr(dev_addr), .ctrl_word(ctrl_word), .ctrl_upd(ctrl_upd)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_word == '0 && !ctrl_upd)); // R1
endmodule

// File: tb/test_trilvl_rx.sv
module test_trilvl_rx;
  localparam int FILT_N = 4;
  localparam int IDLE_W = 16;
  localparam int T_LVL  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_hi = 1'b0, line_lo = 1'b0;
  logic [3:0] dev_addr = 4'h0;
  logic [IDLE_W-1:0] idle_limit = 16'd200;
  logic [22:0] ctrl_word;
  logic ctrl_upd;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [22:0] exp_q[$];
  int          when_q[$];
  logic [6:0]  m_stage = '0;
  logic [22:0] m_word  = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trilvl_rx #(.FILT_N(FILT_N), .IDLE_W(IDLE_W)) i_trilvl_rx (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .dev_addr(dev_addr), .idle_limit(idle_limit),
    .ctrl_word(ctrl_word), .ctrl_upd(ctrl_upd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Scoreboard monitor: each strobe must match the next expected commit in value and cycle.
  always @(negedge clk) begin
    if (rst_n && ctrl_upd) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected strobe", 32'(ctrl_word), 32'hFFFF_FFFF);
      end else begin
        check("R4 committed word", 32'(ctrl_word), 32'(exp_q.pop_front()));
        check("R9 commit cycle", 32'(cyc), 32'(when_q.pop_front()));
      end
    end
  end

  task automatic set_lvl(input int lv);
    line_hi = (lv == 1);
    line_lo = (lv == 2);
  endtask

  // lv: 0 mid, 1 high, 2 low
  task automatic send_bit(input bit b, input bit glitch, input bit last,
                          input logic [22:0] push_word, input bit do_push);
    set_lvl(b ? 1 : 2);
    repeat (T_LVL) @(negedge clk);
    set_lvl(0);
    if (last && do_push) begin
      exp_q.push_back(push_word);
      when_q.push_back(cyc + FILT_N + 4);
    end
    if (glitch) begin
      repeat (30) @(negedge clk);
      set_lvl(b ? 2 : 1);
      repeat (FILT_N - 1) @(negedge clk);
      set_lvl(0);
      repeat (T_LVL - 30 - (FILT_N - 1)) @(negedge clk);
    end else begin
      repeat (T_LVL) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [15:0] hdr, input logic [7:0] adr,
                            input logic [15:0] dat, input int nbits,
                            input bit glitchy, input string req);
    logic [39:0] f = {hdr, adr, dat};
    bit commit = 1'b0;
    if (nbits == 40 && hdr == {8'hFA, dev_addr, 4'hA}) begin
      if (adr == 8'h06) begin
        m_word = {dat, m_stage};
        commit = 1'b1;
      end else if (adr == 8'h07) begin
        m_stage = dat[6:0];
      end
    end
    for (int i = 39; i >= 40 - nbits; i--)
      send_bit(f[i], glitchy && (i % 5 == 0), i == 0, m_word, commit);
    repeat (12) @(negedge clk);
    check(req, 32'(ctrl_word), 32'(m_word));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", 32'(ctrl_word), 32'h0);
    check("R1 reset strobe", 32'(ctrl_upd), 32'h0);
    repeat (20) @(negedge clk);

    // R2 R4: single-frame commit, staged bits still zero
    send_frame(16'hFA0A, 8'h06, 16'h139F, 40, 1'b0, "R2 single frame word");
    // R5: fine write holds output, next coarse commit uses it
    send_frame(16'hFA0A, 8'h07, 16'h000A, 40, 1'b0, "R5 fine write no output change");
    send_frame(16'hFA0A, 8'h06, 16'h139F, 40, 1'b0, "R5 two-frame commit");
    // negative value
    send_frame(16'hFA0A, 8'h07, 16'h000B, 40, 1'b0, "R5 fine write negative");
    send_frame(16'hFA0A, 8'h06, 16'hBD98, 40, 1'b0, "R4 negative commit");
    // R3: wrong device, wrong sync bits
    send_frame(16'hFA3A, 8'h06, 16'h1234, 40, 1'b0, "R3 wrong device dropped");
    send_frame(16'hFB0A, 8'h06, 16'h1234, 40, 1'b0, "R3 wrong sync dropped");
    send_frame(16'hFA0A, 8'h07, 16'h0055, 40, 1'b0, "R3 prep stage");
    send_frame(16'hFA0B, 8'h07, 16'h0011, 40, 1'b0, "R3 bad header keeps stage");
    dev_addr = 4'h5;
    send_frame(16'hFA5A, 8'h06, 16'h0F0F, 40, 1'b0, "R3 programmed device accepted");
    // R6: other register addresses
    send_frame(16'hFA5A, 8'h05, 16'h7777, 40, 1'b0, "R6 address 0x05 dropped");
    send_frame(16'hFA5A, 8'h86, 16'h7777, 40, 1'b0, "R6 address 0x86 dropped");
    // R7: glitches while idle and inside bits
    for (int k = 0; k < 3; k++) begin
      set_lvl(1);
      repeat (FILT_N - 1) @(negedge clk);
      set_lvl(0);
      repeat (40) @(negedge clk);
    end
    send_frame(16'hFA5A, 8'h06, 16'hA5C3, 40, 1'b1, "R7 glitches filtered");
    // R8: broken frame then idle beyond limit
    send_frame(16'hFA5A, 8'h06, 16'h4444, 17, 1'b0, "R8 partial frame no effect");
    repeat (400) @(negedge clk);
    send_frame(16'hFA5A, 8'h06, 16'h2468, 40, 1'b0, "R8 resync after idle");
    // R10: staged bits persist across commits
    send_frame(16'hFA5A, 8'h06, 16'h8001, 40, 1'b0, "R10 stage reused");

    repeat (20) @(negedge clk);
    check("R4 all commits seen", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule